// File: doc/BRIEF.md
# Control Message Mailbox Unit

This block is the low-latency control-message endpoint of a network-on-chip interface. On the receive side it keeps a bank of 64-bit mailboxes, each selected by a tag. A message comes in as three 32-bit flits: a header that carries the destination tag, then the low payload word, then the high payload word. A mailbox is set up either as a plain slot or as a barrier. A plain slot keeps the latest message and a full flag. A barrier merges arrivals by bitwise OR until every bit is set, then empties itself.

In both modes a completed event raises a one-cycle pulse on a per-core notification vector, which can wake idle cores. The pulse goes to the set of cores programmed for that mailbox.

On the transmit side a few shared transmit slots each hold a route and a destination tag. A core sends with a posted store to a slot. The slot then frames the message onto the outgoing flit port. A store to a slot that is still sending is stalled through the write-ready signal and is never lost.

Top module: `ctrl_mailbox`

## Requirements
- R1: After reset every mailbox is empty (reads return data 0 with the full flag 0), `notify` is 0, `txValid` is 0 and no transmit slot is configured.
- R2: Receive framing is three flits accepted whenever `rxValid` is 1: a header whose bits [6:0] are the tag, then payload bits [31:0], then payload bits [63:32]. In a plain mailbox each arrival overwrites the stored value and sets the full flag.
- R3: When a message completes, `notify` carries the mailbox's core mask in the cycle right after the edge that captured the last flit. It returns to 0 in the following cycle. A plain mailbox always notifies. A barrier mailbox notifies only when it completes.
- R4: A read (`coreRdEn`, `coreRdTag`) returns the stored value and full flag on the cycle after the request. On a plain mailbox the read clears the full flag.
- R5: In a barrier mailbox each payload is OR-ed into the stored value. While the result is not all ones, no notification is raised and reads return the partial value. When the result is all ones, the mask is notified and the value clears to 0.
- R6: Transmit framing: the header is {route[15:0], 9'b0, tag[6:0]}, then payload [31:0], then payload [63:32]. Each flit is held stable while `txValid` is 1 and `txReady` is 0.
- R7: A send to a slot that is still busy holds `coreWrReady` at 0 until the slot frees up. The send is then taken and transmitted, never dropped, while sends to idle slots are still accepted.
- R8: A send to a slot that has never been configured is accepted, and no flit is transmitted for it.
- R9: When the transmitter is idle and several slots are pending, the lowest-numbered slot is sent first.
- R10: Core write operations are selected by `coreWrOp`. 0 configures slot `coreWrIdx`, with route = data[47:32] and tag = data[6:0]. 1 configures mailbox `coreWrIdx`, with core mask = data[16:0] and barrier mode = data[32]; this also clears its value and full flag. 2 sends data on slot `coreWrIdx`. 3 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreWrEn | input | 1 | Core write request |
| coreWrOp | input | 2 | Write operation code (R10) |
| coreWrIdx | input | 7 | Mailbox tag or transmit slot index |
| coreWrData | input | 64 | Write data / send payload |
| coreWrReady | output | 1 | Write accepted this cycle when high |
| coreRdEn | input | 1 | Mailbox read request |
| coreRdTag | input | 7 | Mailbox to read |
| coreRdData | output | 64 | Read value, valid the cycle after the request |
| coreRdFull | output | 1 | Full flag of the read mailbox |
| rxValid | input | 1 | Incoming flit valid |
| rxData | input | 32 | Incoming flit |
| txValid | output | 1 | Outgoing flit valid |
| txReady | input | 1 | Network accepts the outgoing flit |
| txData | output | 32 | Outgoing flit |
| notify | output | 17 | Per-core wake pulse |

## Verification
The bench uses the default parameters: 128 mailboxes, 4 transmit slots and 17 cores. With these values it can reach the top tag 127 and a full 17-bit wake mask. With four slots, three sends can queue behind a stalled transmission while a fourth slot stays unconfigured. This lets the bench check lowest-index ordering, stalls on a busy slot, and the silent discard of an unconfigured send in one sequence.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam int MSG_W   = 64;
  localparam int FLIT_W  = 32;
  localparam int ROUTE_W = 16;

  typedef enum logic [1:0] {
    OP_CFG_TX  = 2'd0,
    OP_CFG_BOX = 2'd1,
    OP_SEND    = 2'd2,
    OP_NONE    = 2'd3
  } coreOp_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_LO   = 2'd2,
    PH_HI   = 2'd3
  } txPhase_e;

  typedef struct packed {
    logic rxCommit;
    logic sendAccept;
    logic txRelease;
  } strobes_t;
endpackage

// File: rtl/cmb_ctrl.sv
module cmb_ctrl
  import cmb_pkg::*;
#(
  parameter int NUM_BOX = 128,
  parameter int NUM_TX  = 4,
  localparam int TAG_W  = $clog2(NUM_BOX),
  localparam int SLOT_W = (NUM_TX > 1) ? $clog2(NUM_TX) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [FLIT_W-1:0] rxData,
  input  logic              wrEn,
  input  logic [1:0]        wrOp,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [NUM_TX-1:0] slotBusy,
  input  logic              txReady,
  output logic              txValid,
  output txPhase_e          txPhase,
  output logic [SLOT_W-1:0] curSlot,
  output logic              coreWrReady,
  output logic [TAG_W-1:0]  rxTag,
  output logic [MSG_W-1:0]  rxPayload,
  output strobes_t          stb
);
  // receive flit sequencer
  logic [1:0]        rxPhase;
  logic [TAG_W-1:0]  rxTagQ;
  logic [FLIT_W-1:0] rxLowQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPhase <= 2'd0;
      rxTagQ  <= '0;
      rxLowQ  <= '0;
    end else if (rxValid) begin
      case (rxPhase)
        2'd0: begin rxTagQ <= rxData[TAG_W-1:0]; rxPhase <= 2'd1; end
        2'd1: begin rxLowQ <= rxData;            rxPhase <= 2'd2; end
        default: rxPhase <= 2'd0;
      endcase
    end
  end

  assign rxTag     = rxTagQ;
  assign rxPayload = {rxData, rxLowQ};

  // core send acceptance
  logic sendReq;
  assign sendReq     = wrEn && (wrOp == OP_SEND);
  assign coreWrReady = !((wrOp == OP_SEND) && slotBusy[wrSlot]);

  // lowest pending slot
  logic [SLOT_W-1:0] pickSlot;
  always_comb begin
    pickSlot = '0;
    for (int i = NUM_TX - 1; i >= 0; i--) begin
      if (slotBusy[i]) pickSlot = SLOT_W'(i);
    end
  end

  // transmit serializer
  txPhase_e txState;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= PH_IDLE;
      curSlot <= '0;
    end else begin
      case (txState)
        PH_IDLE: if (|slotBusy) begin
          txState <= PH_HDR;
          curSlot <= pickSlot;
        end
        PH_HDR:  if (txReady) txState <= PH_LO;
        PH_LO:   if (txReady) txState <= PH_HI;
        default: if (txReady) txState <= PH_IDLE;
      endcase
    end
  end

  assign txValid = (txState != PH_IDLE);
  assign txPhase = txState;

  always_comb begin
    stb            = '0;
    stb.rxCommit   = rxValid && (rxPhase == 2'd2);
    stb.sendAccept = sendReq && coreWrReady;
    stb.txRelease  = (txState == PH_HI) && txReady;
  end
endmodule

// File: rtl/cmb_datapath.sv
module cmb_datapath
  import cmb_pkg::*;
#(
  parameter int NUM_BOX  = 128,
  parameter int NUM_TX   = 4,
  parameter int NUM_CORE = 17,
  localparam int TAG_W   = $clog2(NUM_BOX),
  localparam int SLOT_W  = (NUM_TX > 1) ? $clog2(NUM_TX) : 1,
  localparam int PAD_W   = FLIT_W - ROUTE_W - TAG_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [TAG_W-1:0]    rxTag,
  input  logic [MSG_W-1:0]    rxPayload,
  input  logic                wrEn,
  input  logic [1:0]          wrOp,
  input  logic [TAG_W-1:0]    wrIdx,
  input  logic [MSG_W-1:0]    wrData,
  input  logic                rdEn,
  input  logic [TAG_W-1:0]    rdTag,
  output logic [MSG_W-1:0]    rdData,
  output logic                rdFull,
  output logic [NUM_CORE-1:0] notify,
  input  txPhase_e            txPhase,
  input  logic [SLOT_W-1:0]   curSlot,
  output logic [NUM_TX-1:0]   slotBusy,
  output logic [FLIT_W-1:0]   txData
);
  logic [MSG_W-1:0]    boxVal  [NUM_BOX];
  logic [NUM_CORE-1:0] boxMask [NUM_BOX];
  logic [NUM_BOX-1:0]  boxFull;
  logic [NUM_BOX-1:0]  boxBarrier;

  logic [ROUTE_W-1:0]  slotRoute [NUM_TX];
  logic [TAG_W-1:0]    slotTag   [NUM_TX];
  logic [MSG_W-1:0]    slotMsg   [NUM_TX];
  logic [NUM_TX-1:0]   slotCfgd;

  logic [SLOT_W-1:0]   wrSlot;
  logic                cfgBox, cfgTx;
  logic [MSG_W-1:0]    rxAcc;

  assign wrSlot = wrIdx[SLOT_W-1:0];
  assign cfgBox = wrEn && (wrOp == OP_CFG_BOX);
  assign cfgTx  = wrEn && (wrOp == OP_CFG_TX);
  assign rxAcc  = boxVal[rxTag] | rxPayload;

  // mailbox bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BOX; i++) begin
        boxVal[i]  <= '0;
        boxMask[i] <= '0;
      end
      boxFull    <= '0;
      boxBarrier <= '0;
      rdData     <= '0;
      rdFull     <= 1'b0;
      notify     <= '0;
    end else begin
      notify <= '0;
      if (cfgBox) begin
        boxBarrier[wrIdx] <= wrData[32];
        boxMask[wrIdx]    <= wrData[NUM_CORE-1:0];
        boxVal[wrIdx]     <= '0;
        boxFull[wrIdx]    <= 1'b0;
      end
      if (rdEn) begin
        rdData <= boxVal[rdTag];
        rdFull <= boxFull[rdTag];
        if (!boxBarrier[rdTag]) boxFull[rdTag] <= 1'b0;
      end
      if (stb.rxCommit) begin
        if (boxBarrier[rxTag]) begin
          if (&rxAcc) begin
            boxVal[rxTag] <= '0;
            notify        <= boxMask[rxTag];
          end else begin
            boxVal[rxTag] <= rxAcc;
          end
        end else begin
          boxVal[rxTag]  <= rxPayload;
          boxFull[rxTag] <= 1'b1;
          notify         <= boxMask[rxTag];
        end
      end
    end
  end

  // transmit slots
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_TX; s++) begin
        slotRoute[s] <= '0;
        slotTag[s]   <= '0;
        slotMsg[s]   <= '0;
      end
      slotCfgd <= '0;
      slotBusy <= '0;
    end else begin
      if (cfgTx) begin
        slotRoute[wrSlot] <= wrData[32 +: ROUTE_W];
        slotTag[wrSlot]   <= wrData[TAG_W-1:0];
        slotCfgd[wrSlot]  <= 1'b1;
      end
      if (stb.txRelease) slotBusy[curSlot] <= 1'b0;
      if (stb.sendAccept && slotCfgd[wrSlot]) begin
        slotBusy[wrSlot] <= 1'b1;
        slotMsg[wrSlot]  <= wrData;
      end
    end
  end

  always_comb begin
    case (txPhase)
      PH_HDR:  txData = {slotRoute[curSlot], {PAD_W{1'b0}}, slotTag[curSlot]};
      PH_LO:   txData = slotMsg[curSlot][FLIT_W-1:0];
      PH_HI:   txData = slotMsg[curSlot][MSG_W-1:FLIT_W];
      default: txData = '0;
    endcase
  end
endmodule

// File: rtl/ctrl_mailbox.sv
module ctrl_mailbox
  import cmb_pkg::*;
#(
  parameter int NUM_BOX  = 128,
  parameter int NUM_TX   = 4,
  parameter int NUM_CORE = 17,
  localparam int TAG_W   = $clog2(NUM_BOX),
  localparam int SLOT_W  = (NUM_TX > 1) ? $clog2(NUM_TX) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                coreWrEn,
  input  logic [1:0]          coreWrOp,
  input  logic [TAG_W-1:0]    coreWrIdx,
  input  logic [MSG_W-1:0]    coreWrData,
  output logic                coreWrReady,
  input  logic                coreRdEn,
  input  logic [TAG_W-1:0]    coreRdTag,
  output logic [MSG_W-1:0]    coreRdData,
  output logic                coreRdFull,
  input  logic                rxValid,
  input  logic [FLIT_W-1:0]   rxData,
  output logic                txValid,
  input  logic                txReady,
  output logic [FLIT_W-1:0]   txData,
  output logic [NUM_CORE-1:0] notify
);
  strobes_t          stb;
  txPhase_e          txPhase;
  logic [SLOT_W-1:0] curSlot;
  logic [NUM_TX-1:0] slotBusy;
  logic [TAG_W-1:0]  rxTag;
  logic [MSG_W-1:0]  rxPayload;

  cmb_ctrl #(.NUM_BOX(NUM_BOX), .NUM_TX(NUM_TX)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .rxValid(rxValid), .rxData(rxData),
    .wrEn(coreWrEn), .wrOp(coreWrOp), .wrSlot(coreWrIdx[SLOT_W-1:0]),
    .slotBusy(slotBusy), .txReady(txReady),
    .txValid(txValid), .txPhase(txPhase), .curSlot(curSlot),
    .coreWrReady(coreWrReady), .rxTag(rxTag), .rxPayload(rxPayload),
    .stb(stb)
  );

  cmb_datapath #(.NUM_BOX(NUM_BOX), .NUM_TX(NUM_TX), .NUM_CORE(NUM_CORE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rxTag(rxTag), .rxPayload(rxPayload),
    .wrEn(coreWrEn), .wrOp(coreWrOp), .wrIdx(coreWrIdx), .wrData(coreWrData),
    .rdEn(coreRdEn), .rdTag(coreRdTag), .rdData(coreRdData), .rdFull(coreRdFull),
    .notify(notify), .txPhase(txPhase), .curSlot(curSlot),
    .slotBusy(slotBusy), .txData(txData)
  );
endmodule

// File: rtl/ctrl_mailbox_chk.sv
module ctrl_mailbox_chk #(
  parameter int NUM_CORE = 17
) (
  input logic                clk,
  input logic                rstN,
  input logic                rxValid,
  input logic                txValid,
  input logic                txReady,
  input logic [31:0]         txData,
  input logic [NUM_CORE-1:0] notify
);
  // R3: a wake pulse only follows an accepted receive flit
  a_r3_notify_after_flit: assert property (@(posedge clk) disable iff (!rstN)
    (|notify) |-> $past(rxValid));

  // R3: the wake pulse lasts one cycle
  a_r3_notify_single: assert property (@(posedge clk) disable iff (!rstN)
    (|notify) |=> (notify == '0));

  // R6: a stalled flit stays put
  a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  // R6: valid only drops after a handshake
  a_r6_tx_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txValid) |-> $past(txReady));
endmodule

bind ctrl_mailbox ctrl_mailbox_chk #(.NUM_CORE(NUM_CORE)) u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .txValid(txValid),
  .txReady(txReady), .txData(txData), .notify(notify)
);

// File: tb/ctrl_mailbox_bench.sv
module ctrl_mailbox_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        coreWrEn = 1'b0;
  logic [1:0]  coreWrOp = 2'd3;
  logic [6:0]  coreWrIdx = '0;
  logic [63:0] coreWrData = '0;
  logic        coreWrReady;
  logic        coreRdEn = 1'b0;
  logic [6:0]  coreRdTag = '0;
  logic [63:0] coreRdData;
  logic        coreRdFull;
  logic        rxValid = 1'b0;
  logic [31:0] rxData = '0;
  logic        txValid;
  logic        txReady = 1'b0;
  logic [31:0] txData;
  logic [16:0] notify;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] txLog [64];
  int txCnt = 0;

  always #5 clk = ~clk;

  ctrl_mailbox u_ctrl_mailbox (
    .clk(clk), .rstN(rstN),
    .coreWrEn(coreWrEn), .coreWrOp(coreWrOp), .coreWrIdx(coreWrIdx),
    .coreWrData(coreWrData), .coreWrReady(coreWrReady),
    .coreRdEn(coreRdEn), .coreRdTag(coreRdTag), .coreRdData(coreRdData),
    .coreRdFull(coreRdFull), .rxValid(rxValid), .rxData(rxData),
    .txValid(txValid), .txReady(txReady), .txData(txData), .notify(notify)
  );

  always @(negedge clk) begin
    if (txValid && txReady && txCnt < 64) begin
      txLog[txCnt] = txData;
      txCnt = txCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic coreWrite(input logic [1:0] op, input logic [6:0] idx, input logic [63:0] data);
    @(negedge clk);
    coreWrEn = 1'b1; coreWrOp = op; coreWrIdx = idx; coreWrData = data;
    while (!coreWrReady) @(negedge clk);
    @(negedge clk);
    coreWrEn = 1'b0; coreWrOp = 2'd3;
  endtask

  task automatic rdBox(input logic [6:0] tag, output logic [63:0] data, output logic full);
    @(negedge clk);
    coreRdEn = 1'b1; coreRdTag = tag;
    @(negedge clk);
    data = coreRdData; full = coreRdFull;
    coreRdEn = 1'b0;
  endtask

  task automatic rxMsg(input logic [6:0] tag, input logic [63:0] payload, output logic [16:0] n);
    @(negedge clk);
    rxValid = 1'b1; rxData = {16'hF00D, 9'h0, tag};
    @(negedge clk);
    rxData = payload[31:0];
    @(negedge clk);
    rxData = payload[63:32];
    @(negedge clk);
    rxValid = 1'b0;
    n = notify;
  endtask

  task automatic tReset();
    logic [63:0] d; logic f;
    chk(notify == '0, "R1 notify", 64'(notify), 64'h0);
    chk(txValid == 1'b0, "R1 txValid", 64'(txValid), 64'h0);
    rdBox(7'd5, d, f);
    chk(d == 64'h0 && f == 1'b0, "R1 empty box", d, 64'h0);
  endtask

  task automatic tPlain();
    logic [63:0] d; logic f; logic [16:0] n;
    coreWrite(2'd1, 7'd10, 64'h0000_0000_0001_0005);
    rxMsg(7'd10, 64'h1122334455667788, n);
    chk(n == 17'h10005, "R3 plain notify", 64'(n), 64'h10005);
    @(negedge clk);
    chk(notify == '0, "R3 pulse ends", 64'(notify), 64'h0);
    rdBox(7'd10, d, f);
    chk(d == 64'h1122334455667788 && f, "R2 plain store", d, 64'h1122334455667788);
    rdBox(7'd10, d, f);
    chk(f == 1'b0, "R4 read clears full", 64'(f), 64'h0);
    rxMsg(7'd10, 64'hAAAA0000BBBB1111, n);
    rxMsg(7'd10, 64'h0123456789ABCDEF, n);
    rdBox(7'd10, d, f);
    chk(d == 64'h0123456789ABCDEF && f, "R2 overwrite", d, 64'h0123456789ABCDEF);
  endtask

  task automatic tBarrier();
    logic [63:0] d; logic f; logic [16:0] n;
    coreWrite(2'd1, 7'd127, 64'h0000_0001_0001_FFFF);
    rxMsg(7'd127, 64'hFFFF0000FFFF0000, n);
    chk(n == '0, "R5 no early notify", 64'(n), 64'h0);
    rdBox(7'd127, d, f);
    chk(d == 64'hFFFF0000FFFF0000 && !f, "R5 partial value", d, 64'hFFFF0000FFFF0000);
    rxMsg(7'd127, 64'h0000FFFF0000FFFF, n);
    chk(n == 17'h1FFFF, "R5 barrier notify", 64'(n), 64'h1FFFF);
    rdBox(7'd127, d, f);
    chk(d == 64'h0, "R5 barrier clears", d, 64'h0);
  endtask

  task automatic tReconfig();
    logic [63:0] d; logic f; logic [16:0] n;
    rxMsg(7'd10, 64'h5555666677778888, n);
    coreWrite(2'd1, 7'd10, 64'h1);
    rdBox(7'd10, d, f);
    chk(d == 64'h0 && !f, "R10 config clears box", d, 64'h0);
  endtask

  task automatic tTx();
    int base;
    txReady = 1'b1;
    coreWrite(2'd0, 7'd2, 64'h0000_ABCD_0000_0055);
    base = txCnt;
    coreWrite(2'd2, 7'd2, 64'hDEADBEEF01234567);
    repeat (8) @(negedge clk);
    chk(txCnt == base + 3, "R6 flit count", 64'(txCnt - base), 64'd3);
    chk(txLog[base] == 32'hABCD0055, "R6 header", 64'(txLog[base]), 64'hABCD0055);
    chk(txLog[base+1] == 32'h01234567, "R6 low word", 64'(txLog[base+1]), 64'h01234567);
    chk(txLog[base+2] == 32'hDEADBEEF, "R6 high word", 64'(txLog[base+2]), 64'hDEADBEEF);
  endtask

  task automatic tUnconf();
    int base;
    base = txCnt;
    coreWrite(2'd2, 7'd3, 64'h1234);
    repeat (8) @(negedge clk);
    chk(txCnt == base, "R8 unconfigured discarded", 64'(txCnt - base), 64'd0);
  endtask

  task automatic tBusy();
    int base;
    coreWrite(2'd0, 7'd0, 64'h0000_0001_0000_0001);
    coreWrite(2'd0, 7'd1, 64'h0000_0002_0000_0002);
    txReady = 1'b0;
    base = txCnt;
    coreWrite(2'd2, 7'd2, 64'h2222222222222222);
    coreWrite(2'd2, 7'd1, 64'hA1A1A1A1A0A0A0A0);
    coreWrite(2'd2, 7'd0, 64'hB1B1B1B1B0B0B0B0);
    @(negedge clk);
    coreWrEn = 1'b1; coreWrOp = 2'd2; coreWrIdx = 7'd1; coreWrData = 64'hC1C1C1C1C0C0C0C0;
    @(negedge clk);
    chk(coreWrReady == 1'b0, "R7 busy slot stalls", 64'(coreWrReady), 64'h0);
    chk(txValid && txData == 32'hABCD0055, "R6 stalled header", 64'(txData), 64'hABCD0055);
    txReady = 1'b1;
    while (!coreWrReady) @(negedge clk);
    @(negedge clk);
    coreWrEn = 1'b0; coreWrOp = 2'd3;
    repeat (20) @(negedge clk);
    chk(txCnt == base + 12, "R7 all sends carried", 64'(txCnt - base), 64'd12);
    chk(txLog[base+3] == 32'h00010001, "R9 lowest slot first", 64'(txLog[base+3]), 64'h00010001);
    chk(txLog[base+6] == 32'h00020002, "R9 next slot", 64'(txLog[base+6]), 64'h00020002);
    chk(txLog[base+7] == 32'hA0A0A0A0, "R7 first payload", 64'(txLog[base+7]), 64'hA0A0A0A0);
    chk(txLog[base+10] == 32'hC0C0C0C0, "R7 held send low", 64'(txLog[base+10]), 64'hC0C0C0C0);
    chk(txLog[base+11] == 32'hC1C1C1C1, "R7 held send high", 64'(txLog[base+11]), 64'hC1C1C1C1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPlain();
    tBarrier();
    tReconfig();
    tTx();
    tUnconf();
    tBusy();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule